// File: doc/BRIEF.md
# Front-End Event Packet Framer

This block turns one event's worth of digitised drift-time samples into a fixed-length stream of 20-bit words. The stream is framed by two control strobes. A framing strobe marks an opening all-ones word and a closing all-zeros word. A data strobe marks every word in between. After the opening word the block sends a short header: a fixed detector identifier, the event number, the module address, a flag word and the low bits of a beam clock count. Then come the packed sample words, four 5-bit samples to a word, with the earliest sample in the low bits. Channels are visited in an interleaved order that pairs each channel with the one half a board set above it. The packet ends with two user words, a status word, a zero word, a longitudinal parity word and the closing word.

A one-cycle start pulse begins a packet. A pair-select input chooses which of two board pairs is read. The sample buffer sits outside the block and is reached through a registered read port. The block drives an address and a bank bit, and it receives four consecutive samples one cycle later. All header and trailer fields are captured in the start cycle, so the producer may change them while the packet is being sent.

Top module: `evt_packet_framer`

## Requirements
- R1: Every accepted start produces exactly 972 consecutive output words. Word 1 is 0xFFFFF and word 972 is 0x00000, both with out_cav=1 and out_dav=0. Words 2 to 971 carry out_cav=0 and out_dav=1. The first word appears on the outputs on the clock edge that samples start high.
- R2: Words 2 to 6 are, in this order: 0x00300, the event number, the module address, the flag word and the beam clock count.
- R3: Words 7 to 966 are 960 data words, 12 per channel. Channel word w (0..11) is taken from rd_data, which the buffer returns one cycle after rd_en with rd_addr. The address is channel*48 + 4*w. rd_data holds the sample at that address in bits 4-0 and the next three samples in bits 9-5, 14-10 and 19-15.
- R4: Data channels are read in the order 0, 40, 1, 41, ... 39, 79 as buffer channel indices. Even position k reads channel k/2, and odd position k reads channel (k-1)/2 + 40.
- R5: rd_bank equals the pair_sel value sampled with the accepted start, and it stays constant for the whole packet.
- R6: Words 967, 968, 969 and 970 are user1, user2, status_w and 0x00000.
- R7: Word 971 is the bitwise XOR of words 2 through 970.
- R8: busy is high from the first word to the last. A start pulse while busy is high, including during the last word, is ignored. A start in the cycle after busy falls is accepted.
- R9: All header and trailer fields are taken from the inputs in the start cycle. Changes to those inputs during the packet have no effect on it.
- R10: Bits 19-16 of the event number word are zero, and the beam clock word is zero above bit 7.
- R11: While no packet is being sent, out_word is 0, out_cav, out_dav, busy and rd_en are 0, and the same holds during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, one cycle |
| pair_sel | input | 1 | Board pair to read, sampled with start |
| evt_num | input | 16 | Event number |
| mod_addr | input | 20 | Module address word |
| flags | input | 20 | Flag word |
| bclk_cnt | input | 8 | Beam clock count, low bits |
| user1 | input | 20 | First user word |
| user2 | input | 20 | Second user word |
| status_w | input | 20 | Status word |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | 12 | Buffer address of the first of four samples |
| rd_bank | output | 1 | Buffer bank, the latched board pair |
| rd_data | input | 20 | Four samples, returned one cycle after rd_en |
| out_word | output | 20 | Output word |
| out_cav | output | 1 | Framing strobe for the opening and closing words |
| out_dav | output | 1 | Data strobe for all other words |
| busy | output | 1 | Packet in progress |

## Verification
The bench builds the block with its default parameters: 80 channels, 48 samples per channel and four samples per word. The full 972-word frame is therefore exercised. The interleave crosses the 40-channel pairing boundary, and the 12-word channel groups wrap exactly as in service. With those values the bench can reach several cases: a start pulse on the closing word, a back-to-back packet on the opposite board pair in the very next cycle, and header inputs that change mid-packet. It also covers all-ones extreme field values that expose the zero-extended event and clock words.

// File: rtl/evt_packet_framer.sv
module evt_packet_framer #(
  parameter int NCH   = 80,
  parameter int NSAMP = 48,
  parameter int SW    = 5,
  parameter int SPW   = 4,
  parameter int EVW   = 16,
  parameter int BCW   = 8,
  parameter logic [SW*SPW-1:0] DET_ID = 20'h00300
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 pair_sel,
  input  logic [EVW-1:0]       evt_num,
  input  logic [SW*SPW-1:0]    mod_addr,
  input  logic [SW*SPW-1:0]    flags,
  input  logic [BCW-1:0]       bclk_cnt,
  input  logic [SW*SPW-1:0]    user1,
  input  logic [SW*SPW-1:0]    user2,
  input  logic [SW*SPW-1:0]    status_w,
  output logic                 rd_en,
  output logic [$clog2(NCH*NSAMP)-1:0] rd_addr,
  output logic                 rd_bank,
  input  logic [SW*SPW-1:0]    rd_data,
  output logic [SW*SPW-1:0]    out_word,
  output logic                 out_cav,
  output logic                 out_dav,
  output logic                 busy
);
  localparam int WW     = SW * SPW;
  localparam int WPC    = NSAMP / SPW;
  localparam int HALF   = NCH / 2;
  localparam int NDAT   = NCH * WPC;
  localparam int IDAT0  = 6;
  localparam int IDATL  = IDAT0 + NDAT - 1;
  localparam int IEND   = IDATL + 6;
  localparam int PW     = $clog2(IEND + 1);
  localparam int AW     = $clog2(NCH * NSAMP);
  localparam int KW     = $clog2(NCH + 1);
  localparam int FW     = $clog2(WPC + 1);

  localparam logic [PW-1:0] P_DAT0 = PW'(IDAT0);
  localparam logic [PW-1:0] P_DATL = PW'(IDATL);
  localparam logic [PW-1:0] P_U1   = PW'(IDATL + 1);
  localparam logic [PW-1:0] P_U2   = PW'(IDATL + 2);
  localparam logic [PW-1:0] P_ST   = PW'(IDATL + 3);
  localparam logic [PW-1:0] P_ZR   = PW'(IDATL + 4);
  localparam logic [PW-1:0] P_PAR  = PW'(IDATL + 5);
  localparam logic [PW-1:0] P_END  = PW'(IEND);
  localparam logic [PW-1:0] P_FLO  = PW'(IDAT0 - 2);
  localparam logic [PW-1:0] P_FHI  = PW'(IDATL - 2);

  logic [PW-1:0]  pos;
  logic [KW-1:0]  fk;
  logic [FW-1:0]  fw;
  logic [WW-1:0]  par;
  logic [EVW-1:0] c_evt;
  logic [BCW-1:0] c_bclk;
  logic [WW-1:0]  c_mod, c_flg, c_u1, c_u2, c_st;
  logic [WW-1:0]  nw;

  wire go    = start && !busy;
  wire last  = busy && (pos == P_END);
  wire load  = go || (busy && !last);
  wire [PW-1:0] np = go ? '0 : pos + PW'(1);
  wire fetch = busy && (pos >= P_FLO) && (pos <= P_FHI);
  wire edge_w = (np == '0) || (np == P_END);

  wire [KW-1:0] chan = fk[0] ? (fk >> 1) + KW'(HALF) : (fk >> 1);
  wire [AW-1:0] addr = AW'(chan) * AW'(NSAMP) + AW'(fw) * AW'(SPW);

  assign rd_en   = fetch;
  assign rd_addr = fetch ? addr : '0;

  always_comb begin
    nw = '0;
    if (np == '0)                          nw = '1;
    else if (np == PW'(1))                 nw = DET_ID;
    else if (np == PW'(2))                 nw = WW'(c_evt);
    else if (np == PW'(3))                 nw = c_mod;
    else if (np == PW'(4))                 nw = c_flg;
    else if (np == PW'(5))                 nw = WW'(c_bclk);
    else if (np >= P_DAT0 && np <= P_DATL) nw = rd_data;
    else if (np == P_U1)                   nw = c_u1;
    else if (np == P_U2)                   nw = c_u2;
    else if (np == P_ST)                   nw = c_st;
    else if (np == P_PAR)                  nw = par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pos      <= '0;
      out_word <= '0;
      out_cav  <= 1'b0;
      out_dav  <= 1'b0;
      par      <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      pos      <= np;
      out_word <= nw;
      out_cav  <= edge_w;
      out_dav  <= !edge_w;
      if (np == '0)
        par <= '0;
      else if (np <= P_ZR)
        par <= par ^ nw;
    end else if (last) begin
      busy     <= 1'b0;
      pos      <= '0;
      out_word <= '0;
      out_cav  <= 1'b0;
      out_dav  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fk <= '0;
      fw <= '0;
    end else if (go) begin
      fk <= '0;
      fw <= '0;
    end else if (fetch) begin
      if (fw == FW'(WPC - 1)) begin
        fw <= '0;
        fk <= fk + KW'(1);
      end else begin
        fw <= fw + FW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bank <= 1'b0;
      c_evt   <= '0;
      c_bclk  <= '0;
      c_mod   <= '0;
      c_flg   <= '0;
      c_u1    <= '0;
      c_u2    <= '0;
      c_st    <= '0;
    end else if (go) begin
      rd_bank <= pair_sel;
      c_evt   <= evt_num;
      c_bclk  <= bclk_cnt;
      c_mod   <= mod_addr;
      c_flg   <= flags;
      c_u1    <= user1;
      c_u2    <= user2;
      c_st    <= status_w;
    end
  end
endmodule

module evt_packet_framer_chk #(
  parameter int WW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          out_cav,
  input logic          out_dav,
  input logic [WW-1:0] out_word,
  input logic          rd_en,
  input logic          rd_bank
);
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (out_cav ^ out_dav));

  a_r1_open_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (out_cav && out_word == '1));

  a_r1_close_word: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(out_cav) && $past(out_word) == '0));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_cav && !out_dav && out_word == '0 && !rd_en));

  a_r5_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_bank));

  a_r3_read_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);
endmodule

bind evt_packet_framer evt_packet_framer_chk #(.WW(SW*SPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .out_cav(out_cav), .out_dav(out_dav),
  .out_word(out_word), .rd_en(rd_en), .rd_bank(rd_bank)
);

// File: tb/sim_evt_packet_framer.sv
module sim_evt_packet_framer;
  localparam int CLK_NS = 10;
  localparam int PKT    = 972;
  localparam int NCH    = 80;
  localparam int NSAMP  = 48;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0, pair_sel = 0;
  logic [15:0] evt_num = 0;
  logic [7:0]  bclk_cnt = 0;
  logic [19:0] mod_addr = 0, flags = 0, user1 = 0, user2 = 0, status_w = 0;
  logic rd_en, rd_bank;
  logic [11:0] rd_addr;
  logic [19:0] rd_data = 0;
  logic [19:0] out_word;
  logic out_cav, out_dav, busy;

  int total = 0, bad = 0, seed = 3;
  int m_busy = 0, m_pos = 0, m_bank = 0, pkts = 0, run_len = 0;
  logic [19:0] exp_w [0:PKT-1];

  always #(CLK_NS/2) clk = ~clk;

  evt_packet_framer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pair_sel(pair_sel),
    .evt_num(evt_num), .mod_addr(mod_addr), .flags(flags), .bclk_cnt(bclk_cnt),
    .user1(user1), .user2(user2), .status_w(status_w),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_bank(rd_bank), .rd_data(rd_data),
    .out_word(out_word), .out_cav(out_cav), .out_dav(out_dav), .busy(busy)
  );

  function automatic logic [4:0] sv(int b, int a);
    int v;
    v = (a * 37 + b * 19 + seed * 5 + a / 8) % 32;
    if ((a % 11) == 3) v = 0;
    return v[4:0];
  endfunction

  function automatic logic [19:0] four(int b, int a);
    return {sv(b, a + 3), sv(b, a + 2), sv(b, a + 1), sv(b, a)};
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= four(rd_bank, rd_addr);

  task automatic build();
    logic [19:0] p;
    exp_w[0] = 20'hFFFFF;
    exp_w[1] = 20'h00300;
    exp_w[2] = {4'h0, evt_num};
    exp_w[3] = mod_addr;
    exp_w[4] = flags;
    exp_w[5] = {12'h000, bclk_cnt};
    for (int d = 0; d < 960; d++) begin
      int k, w, ch;
      k = d / 12; w = d % 12;
      ch = (k % 2 == 0) ? k / 2 : k / 2 + NCH / 2;
      exp_w[6 + d] = four(pair_sel, ch * NSAMP + 4 * w);
    end
    exp_w[966] = user1;
    exp_w[967] = user2;
    exp_w[968] = status_w;
    exp_w[969] = 20'h00000;
    p = 0;
    for (int i = 1; i <= 969; i++) p = p ^ exp_w[i];
    exp_w[970] = p;
    exp_w[971] = 20'h00000;
  endtask

  function automatic string tag(int p);
    if (p == 0 || p == 971) return "R1";
    if (p <= 5)   return "R2/R9/R10";
    if (p <= 965) return "R3/R4";
    if (p <= 969) return "R6/R9";
    return "R7";
  endfunction

  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      m_busy = 0;
    end else if (m_busy == 0 && start) begin
      m_busy = 1; m_pos = 0; m_bank = pair_sel; pkts++; run_len = 0;
      build();
    end else if (m_busy != 0) begin
      m_pos++;
      if (m_pos == PKT) m_busy = 0;
    end
    @(negedge clk);
    total++;
    if (m_busy != 0) begin
      logic ec;
      ec = (m_pos == 0 || m_pos == 971);
      run_len++;
      if (out_word !== exp_w[m_pos]) begin
        bad++;
        $display("FAIL %s word %0d: got %h exp %h", tag(m_pos), m_pos, out_word, exp_w[m_pos]);
      end else if (out_cav !== ec || out_dav !== !ec) begin
        bad++;
        $display("FAIL R1 strobes at word %0d: got cav=%b dav=%b exp cav=%b dav=%b",
                 m_pos, out_cav, out_dav, ec, !ec);
      end else if (busy !== 1'b1) begin
        bad++;
        $display("FAIL R8 busy at word %0d: got %b exp 1", m_pos, busy);
      end else if (rd_bank !== m_bank[0]) begin
        bad++;
        $display("FAIL R5 bank at word %0d: got %b exp %0d", m_pos, rd_bank, m_bank);
      end
    end else begin
      if (out_word !== 0 || out_cav !== 0 || out_dav !== 0 || busy !== 0 || rd_en !== 0) begin
        bad++;
        $display("FAIL R11 idle: got word=%h cav=%b dav=%b busy=%b rd_en=%b exp all 0",
                 out_word, out_cav, out_dav, busy, rd_en);
      end
      if (run_len != 0) begin
        total++;
        if (run_len != PKT) begin
          bad++;
          $display("FAIL R1 length: got %0d exp %0d", run_len, PKT);
        end
        run_len = 0;
      end
    end
  endtask

  task automatic set_fields(int v);
    evt_num  = 16'(v * 4099 + 17);
    mod_addr = 20'(v * 70001 + 5);
    flags    = 20'(v * 3 + 20'hA5A5A);
    bclk_cnt = 8'(v * 29 + 1);
    user1    = 20'(v * 123457);
    user2    = 20'(v * 98765 + 1);
    status_w = 20'(v * 11 + 20'h0F0F0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    bad++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    set_fields(1);
    repeat (3) tick();               // R11 during reset
    rst_n = 1;
    repeat (3) tick();               // R11 after reset

    pair_sel = 0; start = 1; tick(); start = 0;
    repeat (300) tick();
    set_fields(7); pair_sel = 1;     // R9: mid-packet changes
    start = 1; tick(); start = 0;    // R8: ignored while busy
    while (m_pos != 971) tick();
    start = 1; tick();               // R8: ignored on last word
    tick(); start = 0;               // R8: accepted right after busy falls
    while (m_busy != 0) tick();
    repeat (4) tick();

    seed = 9; pair_sel = 0;
    evt_num = 16'hFFFF; bclk_cnt = 8'hFF; mod_addr = 20'hFFFFF;
    flags = 20'h00000; user1 = 20'hFFFFF; user2 = 20'h12345; status_w = 20'h80001;
    start = 1; tick(); start = 0;    // R10 extremes
    while (m_busy != 0) tick();
    repeat (3) tick();

    total++;
    if (pkts != 3) begin
      bad++;
      $display("FAIL R8 packets: got %0d exp 3", pkts);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule